// File: doc/BRIEF.md
# Dual Reload Timer with Masked Interrupt

The block holds two identical down-counting timers behind a 32-bit, word-only register bus. Each timer has a divisor, a control word and a readable count. A control write does one of three things: it copies the divisor into the count, it halts the timer, or it starts the timer. The same write also picks which tick enable drives the timer. A running timer counts down by one on each selected tick. When it expires, it reloads from its divisor and raises its own pending bit, so it fires periodically until software halts it.

The two pending bits are ANDed with a mask and ORed onto one interrupt line. Software clears pending bits by writing ones to an acknowledge location. That write is a one-cycle pulse and leaves no stored value behind. A separate free-running time register counts ticks of a fixed time base and wraps at its width. All clock sources arrive as single-cycle tick enables. Reads are combinational from `addr` while `rd_en` is high.

Each timer is a two-state machine. **HALTED** (`T_HOLD`) is the reset state. It moves to **RUNNING** (`T_RUN`) on a run command and returns on a halt command. A load command copies the divisor and leaves the state as it is. The illegal operation code changes nothing.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset both timers are HALTED with count, divisor and control at zero. The pending bits and the mask are zero, and `irq` is low.
- R2: Registers sit at these byte offsets: timer 0 divisor 0x00, count 0x04, control 0x08; timer 1 at 0x10, 0x14, 0x18; time 0x38; mask 0x48; acknowledge 0x4C; raw pending 0x50; masked pending 0x54. An access with `addr[1:0]` not zero, or to any other offset, reads zero and its write has no effect.
- R3: Control operation code 0 (bits [1:0]) loads the divisor into the count and leaves the HALTED/RUNNING state unchanged.
- R4: Operation code 1 enters HALTED, where the count does not change. Operation code 2 enters RUNNING, where the count drops by one per selected tick.
- R5: A control write with operation code 3 is ignored. The control word and the state keep their values.
- R6: Control bits [4:2] select the tick. Code 0 selects `ext_tick`. Codes 4, 5, 6 and 7 select `src_tick[0]`, `[1]`, `[2]` and `[3]`. Codes 1, 2 and 3 select no tick, so the count stays frozen.
- R7: A selected tick in RUNNING with a count of 0 or 1 is an expiry. The count reloads from the divisor, and timer 0 sets pending bit 0 while timer 1 sets pending bit 1. A divisor write changes the count only at the next load or reload.
- R8: The masked pending register reads raw pending AND mask (bits [1:0]). `irq` is high exactly when that value is non-zero.
- R9: Writing ones to the acknowledge location clears the matching pending bits. Reading that location returns zero.
- R10: An expiry and an acknowledge of the same bit in the same cycle leave the bit pending.
- R11: The time register increments by one on each `time_tick` and wraps to zero after its all-ones value.
- R12: A legal control write in the same cycle as a selected tick takes priority, and that tick is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read enable; `rdata` is zero when low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| ext_tick | input | 1 | External tick enable (rate code 0) |
| src_tick | input | 4 | Internal tick enables (rate codes 4 to 7) |
| time_tick | input | 1 | Time-base tick for the time register |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with a 16-bit count and an 8-bit time register. The narrow time register lets a few hundred cycles of time ticks reach its wrap. With a 16-bit count, small divisors give many expiries in a short run. Each tick input is driven at its own fixed period. This makes every rate code count at a different speed. A divisor of one with an every-cycle tick makes an expiry coincide with any acknowledge or control write, which reaches both same-cycle priority rules.

// File: rtl/drt_pkg.sv
package drt_pkg;

    localparam int N_TMR      = 2;
    localparam int CTRL_W     = 5;
    localparam int TMR_STRIDE = 16;

    localparam int OFS_DIV    = 'h00;
    localparam int OFS_CNT    = 'h04;
    localparam int OFS_CTRL   = 'h08;
    localparam int OFS_TIME   = 'h38;
    localparam int OFS_MASK   = 'h48;
    localparam int OFS_ACK    = 'h4C;
    localparam int OFS_RAW    = 'h50;
    localparam int OFS_MSKD   = 'h54;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_HOLD = 2'd1,
        OP_RUN  = 2'd2,
        OP_BAD  = 2'd3
    } drt_op_e;

    typedef enum logic {
        T_HOLD = 1'b0,
        T_RUN  = 1'b1
    } drt_state_e;

endpackage

// File: rtl/drt_timer.sv
module drt_timer
    import drt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_wr,
    input  logic              ctrl_wr,
    input  logic [31:0]       wdata,
    input  logic              ext_tick,
    input  logic [3:0]        src_tick,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  divisor,
    output logic [CTRL_W-1:0] ctrl,
    output logic              expire
);

    drt_state_e          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d, div_q;
    logic [CTRL_W-1:0]   ctrl_q;
    drt_op_e             op;
    logic                cmd_ok;
    logic                tick;

    assign op     = drt_op_e'(wdata[1:0]);
    assign cmd_ok = ctrl_wr && (op != OP_BAD);

    // rate select (R6)
    always_comb begin
        unique case (ctrl_q[4:2])
            3'd0:    tick = ext_tick;
            3'd4:    tick = src_tick[0];
            3'd5:    tick = src_tick[1];
            3'd6:    tick = src_tick[2];
            3'd7:    tick = src_tick[3];
            default: tick = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= T_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        if (cmd_ok) begin
            unique case (op)
                OP_LOAD: cnt_d   = div_q;
                OP_HOLD: state_d = T_HOLD;
                OP_RUN:  state_d = T_RUN;
                OP_BAD:  state_d = state_q;
            endcase
        end else begin
            unique case (state_q)
                T_HOLD: cnt_d = cnt_q;
                T_RUN: begin
                    if (tick) begin
                        if (cnt_q <= CNT_W'(1)) begin
                            cnt_d  = div_q;
                            expire = 1'b1;
                        end else begin
                            cnt_d = cnt_q - CNT_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            div_q  <= '0;
            ctrl_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (div_wr) div_q <= wdata[CNT_W-1:0];
            if (cmd_ok) ctrl_q <= wdata[CTRL_W-1:0];
        end
    end

    assign count   = cnt_q;
    assign divisor = div_q;
    assign ctrl    = ctrl_q;

    a_r4_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_HOLD && !ctrl_wr) |=> $stable(cnt_q));

    a_r7_reload_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == $past(div_q)));

    a_r5_bad_op_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata[1:0] == 2'd3) |=> ($stable(ctrl_q) && $stable(state_q)));

endmodule

// File: rtl/drt_irq.sv
module drt_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] expire,
    input  logic         mask_wr,
    input  logic         ack_wr,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] pending,
    output logic [N-1:0] mask,
    output logic         irq
);

    logic [N-1:0] pend_q, mask_q, clr;

    assign clr = ack_wr ? wbits : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr) | expire;
            if (mask_wr) mask_q <= wbits;
        end
    end

    assign pending = pend_q;
    assign mask    = mask_q;
    assign irq     = |(pend_q & mask_q);

    a_r10_expiry_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|expire) |=> ((pend_q & $past(expire)) == $past(expire)));

    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> ((pend_q & $past(wbits & ~expire)) == '0));

    a_r8_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_wr && expire == '0) |=> $stable(pend_q));

endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
    import drt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32,
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              ext_tick,
    input  logic [3:0]        src_tick,
    input  logic              time_tick,
    output logic              irq
);

    logic               aligned;
    logic               wr_ok;
    logic [CNT_W-1:0]   t_count [N_TMR];
    logic [CNT_W-1:0]   t_div   [N_TMR];
    logic [CTRL_W-1:0]  t_ctrl  [N_TMR];
    logic [N_TMR-1:0]   t_expire;
    logic [N_TMR-1:0]   pend, mask;
    logic [TIME_W-1:0]  time_q;
    logic [31:0]        rd_c;

    assign aligned = (addr[1:0] == 2'b00);
    assign wr_ok   = wr_en && aligned;

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        localparam int BASE = g * TMR_STRIDE;
        drt_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .div_wr   (wr_ok && addr == ADDR_W'(BASE + OFS_DIV)),
            .ctrl_wr  (wr_ok && addr == ADDR_W'(BASE + OFS_CTRL)),
            .wdata    (wdata),
            .ext_tick (ext_tick),
            .src_tick (src_tick),
            .count    (t_count[g]),
            .divisor  (t_div[g]),
            .ctrl     (t_ctrl[g]),
            .expire   (t_expire[g])
        );
    end

    drt_irq #(.N(N_TMR)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (t_expire),
        .mask_wr (wr_ok && addr == ADDR_W'(OFS_MASK)),
        .ack_wr  (wr_ok && addr == ADDR_W'(OFS_ACK)),
        .wbits   (wdata[N_TMR-1:0]),
        .pending (pend),
        .mask    (mask),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= '0;
        end else if (time_tick) begin
            time_q <= time_q + TIME_W'(1);
        end
    end

    always_comb begin
        rd_c = '0;
        if (aligned) begin
            for (int i = 0; i < N_TMR; i++) begin
                if (addr == ADDR_W'(i * TMR_STRIDE + OFS_DIV))  rd_c = 32'(t_div[i]);
                if (addr == ADDR_W'(i * TMR_STRIDE + OFS_CNT))  rd_c = 32'(t_count[i]);
                if (addr == ADDR_W'(i * TMR_STRIDE + OFS_CTRL)) rd_c = 32'(t_ctrl[i]);
            end
            if (addr == ADDR_W'(OFS_TIME)) rd_c = 32'(time_q);
            if (addr == ADDR_W'(OFS_MASK)) rd_c = 32'(mask);
            if (addr == ADDR_W'(OFS_RAW))  rd_c = 32'(pend);
            if (addr == ADDR_W'(OFS_MSKD)) rd_c = 32'(pend & mask);
        end
    end

    assign rdata = rd_en ? rd_c : 32'd0;

    a_r11_time_step: assert property (@(posedge clk) disable iff (!rst_n)
        time_tick |=> (time_q == TIME_W'($past(time_q) + TIME_W'(1))));

    a_r11_time_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !time_tick |=> $stable(time_q));

endmodule

// File: tb/test_dual_reload_timer.sv
module test_dual_reload_timer;

    localparam int CW = 16;
    localparam int TW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ext_tick = 1'b0, time_tick = 1'b0;
    logic [3:0]  src_tick = '0;
    logic        irq;

    int checks = 0, fails = 0, cyc = 0;
    string phase = "R1 reset";

    dual_reload_timer #(.ADDR_W(8), .CNT_W(CW), .TIME_W(TW)) i_dual_reload_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ext_tick(ext_tick), .src_tick(src_tick),
        .time_tick(time_tick), .irq(irq));

    always #10 clk = ~clk;

    // reference model state
    bit [CW-1:0] m_div [2];
    bit [CW-1:0] m_cnt [2];
    bit [4:0]    m_ctrl [2];
    bit          m_run [2];
    bit [1:0]    m_pend, m_mask, m_exp;
    bit [TW-1:0] m_time;

    function automatic bit sel_tick(bit [4:0] c);
        case (c[4:2])
            3'd0: return ext_tick;
            3'd4: return src_tick[0];
            3'd5: return src_tick[1];
            3'd6: return src_tick[2];
            3'd7: return src_tick[3];
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int t = 0; t < 2; t++) begin
                m_div[t] = 0; m_cnt[t] = 0; m_ctrl[t] = 0; m_run[t] = 0;
            end
            m_pend = 0; m_mask = 0; m_time = 0;
        end else begin
            m_exp = 0;
            for (int t = 0; t < 2; t++) begin
                if (wr_en && addr == 8'(t*16 + 8) && wdata[1:0] != 2'd3) begin
                    m_ctrl[t] = wdata[4:0];
                    if (wdata[1:0] == 2'd0) m_cnt[t] = m_div[t];
                    if (wdata[1:0] == 2'd1) m_run[t] = 0;
                    if (wdata[1:0] == 2'd2) m_run[t] = 1;
                end else if (m_run[t] && sel_tick(m_ctrl[t])) begin
                    if (m_cnt[t] <= 1) begin
                        m_cnt[t] = m_div[t];
                        m_exp[t] = 1;
                    end else begin
                        m_cnt[t] = m_cnt[t] - 1;
                    end
                end
                if (wr_en && addr == 8'(t*16)) m_div[t] = wdata[CW-1:0];
            end
            if (wr_en && addr == 8'h4C) m_pend = m_pend & ~wdata[1:0];
            m_pend = m_pend | m_exp;
            if (wr_en && addr == 8'h48) m_mask = wdata[1:0];
            if (time_tick) m_time = m_time + 1;
        end
    end

    function automatic bit [31:0] m_read(bit [7:0] a);
        case (a)
            8'h00: return 32'(m_div[0]);
            8'h04: return 32'(m_cnt[0]);
            8'h08: return 32'(m_ctrl[0]);
            8'h10: return 32'(m_div[1]);
            8'h14: return 32'(m_cnt[1]);
            8'h18: return 32'(m_ctrl[1]);
            8'h38: return 32'(m_time);
            8'h48: return 32'(m_mask);
            8'h50: return 32'(m_pend);
            8'h54: return 32'(m_pend & m_mask);
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
        end
    endtask

    // compare on every clock, just before the rising edge
    always @(negedge clk) begin
        #5;
        if (rst_n) begin
            chk("R8 irq", 32'(irq), 32'(|(m_pend & m_mask)));
            if (rd_en) chk($sformatf("R2 read %h", addr), rdata, m_read(addr));
        end
    end

    // tick sources at fixed distinct periods
    always @(negedge clk) begin
        src_tick[0] <= 1'b1;
        src_tick[1] <= (cyc % 2) == 0;
        src_tick[2] <= (cyc % 3) == 0;
        src_tick[3] <= (cyc % 4) == 0;
        ext_tick    <= (cyc % 5) == 0;
        time_tick   <= (cyc % 2) == 1;
    end

    task automatic wr(bit [7:0] a, bit [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(bit [7:0] a);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_all();
        rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h10); rd(8'h14); rd(8'h18);
        rd(8'h48); rd(8'h4C); rd(8'h50); rd(8'h54);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state after reset
        chk("R1 irq low", 32'(irq), 32'd0);
        rd_all();

        phase = "R2 decode";
        wr(8'h20, 32'hFFFF); wr(8'h01, 32'h7); wr(8'h5C, 32'h3);
        rd(8'h01); rd(8'h20); rd(8'h5C); rd(8'h3C); rd_all();

        phase = "R3 load";
        wr(8'h00, 32'd5);
        rd(8'h04);
        wr(8'h08, 32'h10);             // rate 4, op load
        rd(8'h04); idle(4); rd(8'h04); // R4 stays halted

        phase = "R4 run";
        wr(8'h08, 32'h12);             // rate 4 run
        rd(8'h04); rd(8'h04); rd(8'h04);
        wr(8'h08, 32'h11);             // halt
        rd(8'h04); idle(3); rd(8'h04);

        phase = "R7 expiry";
        wr(8'h00, 32'd3);
        wr(8'h08, 32'h16);             // rate 5 run
        for (int i = 0; i < 12; i++) rd(8'h04);
        rd(8'h50); rd(8'h54);

        phase = "R8 mask";
        wr(8'h48, 32'h1); rd(8'h54); rd(8'h48); idle(2);
        wr(8'h48, 32'h2); rd(8'h54);

        phase = "R9 ack";
        wr(8'h08, 32'h11);
        wr(8'h4C, 32'h1); rd(8'h50); rd(8'h4C); rd(8'h54);

        phase = "R10 ack vs expiry";
        wr(8'h00, 32'd1); wr(8'h48, 32'h3);
        wr(8'h08, 32'h12);             // expires every cycle
        wr(8'h4C, 32'h1); rd(8'h50);
        wr(8'h4C, 32'h3); rd(8'h50);

        phase = "R12 write beats tick";
        wr(8'h00, 32'd4);
        wr(8'h08, 32'h10);
        wr(8'h08, 32'h12);
        wr(8'h08, 32'h12); rd(8'h04);
        wr(8'h08, 32'h10); rd(8'h04);

        phase = "R5 bad op";
        wr(8'h08, 32'h1F); rd(8'h08); rd(8'h04); rd(8'h04);
        wr(8'h08, 32'h11); wr(8'h08, 32'h0B); rd(8'h08); rd(8'h04);

        phase = "R6 rate codes";
        wr(8'h00, 32'd200); wr(8'h08, 32'h00);
        wr(8'h08, 32'h06); idle(6); rd(8'h04);   // code 1: frozen
        wr(8'h08, 32'h0A); idle(6); rd(8'h04);   // code 2: frozen
        wr(8'h08, 32'h0E); idle(6); rd(8'h04);   // code 3: frozen
        wr(8'h08, 32'h02); idle(10); rd(8'h04);  // code 0: ext_tick
        wr(8'h08, 32'h1A); idle(9); rd(8'h04);   // code 6
        wr(8'h08, 32'h1E); idle(8); rd(8'h04);   // code 7

        phase = "R7 timer 1";
        wr(8'h10, 32'd2); wr(8'h18, 32'h1C); wr(8'h18, 32'h1E);
        for (int i = 0; i < 10; i++) rd(8'h14);
        rd(8'h50); wr(8'h4C, 32'h2); rd(8'h50); rd(8'h54);

        phase = "R11 time wrap";
        wr(8'h08, 32'h11); wr(8'h18, 32'h1D);
        for (int i = 0; i < 140; i++) begin
            idle(2); rd(8'h38);
        end

        phase = "R1 reset again";
        @(negedge clk); rst_n = 1'b0;
        idle(2); rst_n = 1'b1;
        chk("R1 irq after reset", 32'(irq), 32'd0);
        rd_all(); rd(8'h38);

        summary();
        $finish;
    end

endmodule